// File: doc/BRIEF.md
# Scan Direction Select with Break-Before-Make Dead Time

This block drives the two complementary enables that tell a gate-driver panel which way to scan: one enable for forward and one for reverse. It also hands the chosen direction to the clock sequencer through a registered output. The direction comes from a raw select input, where 1 means reverse and 0 means forward. The select is also copied into a flag on every rising edge of the frame-start strobe. The block acts on the OR of the raw select and that flag. A high select therefore forces reverse at once. A return to forward waits until a frame-start edge sees the select low. Because of this, the enables stay valid during power-down, when the select pin may float low but the last captured value still says reverse.

Every change of the acted-on direction is break-before-make. Both enables are held low for a fixed number of clock cycles, `DEAD_CYC`, and only then does the newly selected enable rise. If the direction changes again while that gap is running, the count starts over. Nothing else in the panel controller changes this behaviour, including fault or abnormal-frame handling. All inputs are synchronous to `clk`, and all outputs are registered.

Top module: `scan_dir_select`

## Requirements
- R1: Once no gap is running, a forward direction (value 0) drives `drive_fwd`=1 and `drive_rev`=0, and a reverse direction (value 1) drives `drive_fwd`=0 and `drive_rev`=1. The two enables are never high together, and `scan_dir` always shows the direction of whichever enable is high.
- R2: On a clock edge where `frame_strobe` is high and was low at the previous edge, `scan_sel` is stored in the capture flag. A strobe that simply stays high captures nothing.
- R3: A high `scan_sel` selects reverse without waiting for a strobe. `drive_fwd` is low after the first clock edge that sees it, and `scan_dir` reads 1 from that edge on. While the capture flag is clear, the direction follows `scan_sel`.
- R4: While the capture flag holds 1, a low `scan_sel` keeps the reverse direction. Forward returns only after a strobe rising edge samples `scan_sel` low.
- R5: When the acted-on direction changes, both enables go low at the first clock edge that sees the change. They stay low for exactly `DEAD_CYC` clock cycles, and the new enable rises after that.
- R6: A further direction change during a gap reloads the gap. Both enables then stay low for `DEAD_CYC` cycles counted from the edge that saw the latest change.
- R7: While `rst` is high and after it is released, the capture flag is clear and the outputs read forward (`drive_fwd`=1, `drive_rev`=0, `scan_dir`=0), with no gap at start-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_sel | input | 1 | Raw direction select, 1 = reverse, 0 = forward (tie low when unused) |
| frame_strobe | input | 1 | Frame-start strobe; its rising edge captures `scan_sel` |
| drive_fwd | output | 1 | Forward scan enable |
| drive_rev | output | 1 | Reverse scan enable |
| scan_dir | output | 1 | Direction handed to the clock sequencer, 1 = reverse |

## Verification
The bench measures the gap length at the ports. A timer that is off by one would hold the enables low for `DEAD_CYC`±1 cycles, and a version without break-before-make would let one enable rise in the same cycle the other falls. The bench lowers the select after a strobe has captured a high value. A design that acted on the raw select alone would fall back to forward, the very failure at power-down that the capture flag exists to prevent. The bench also flips the select back in the middle of a gap to catch a timer that does not reload and so shortens the second gap. Finally, it holds the strobe high across select changes, so that a design that captures on the strobe's level rather than its edge would store the wrong flag.

// File: rtl/scan_dir_pkg.sv
package scan_dir_pkg;
  typedef enum logic {
    DIR_FWD = 1'b0,
    DIR_REV = 1'b1
  } scan_dir_e;

  function automatic int unsigned gap_cnt_width(input int unsigned cycles);
    return (cycles < 2) ? 1 : $clog2(cycles + 1);
  endfunction
endpackage

// File: rtl/sds_strobe_latch.sv
module sds_strobe_latch
  import scan_dir_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sel_in,
  input  logic      strobe_in,
  output scan_dir_e eff_dir
);
  logic strobe_q;
  logic cap_flag;
  logic strobe_rise;

  // Previous strobe level; follows the input during reset too.
  always_ff @(posedge clk) begin
    strobe_q <= strobe_in;
  end

  assign strobe_rise = strobe_in & ~strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_flag <= 1'b0;
    end else if (strobe_rise) begin
      cap_flag <= sel_in;
    end
  end

  // Raw reverse request wins at once; forward needs a captured low.
  assign eff_dir = scan_dir_e'(sel_in | cap_flag);
endmodule

// File: rtl/sds_gap_timer.sv
module sds_gap_timer
  import scan_dir_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 125
) (
  input  logic      clk,
  input  logic      rst,
  input  scan_dir_e want_dir,
  output logic      en_fwd,
  output logic      en_rev,
  output logic      dir_out
);
  localparam int unsigned CW = gap_cnt_width(DEAD_CYC);
  localparam logic [CW-1:0] LOAD = CW'(DEAD_CYC);

  scan_dir_e     held_dir, held_dir_n;
  logic [CW-1:0] gap_cnt, gap_cnt_n;

  always_comb begin
    held_dir_n = held_dir;
    gap_cnt_n  = gap_cnt;
    if (want_dir != held_dir) begin
      held_dir_n = want_dir;
      gap_cnt_n  = LOAD;
    end else if (gap_cnt != '0) begin
      gap_cnt_n  = gap_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_dir <= DIR_FWD;
      gap_cnt  <= '0;
      en_fwd   <= 1'b1;
      en_rev   <= 1'b0;
      dir_out  <= 1'b0;
    end else begin
      held_dir <= held_dir_n;
      gap_cnt  <= gap_cnt_n;
      en_fwd   <= (gap_cnt_n == '0) && (held_dir_n == DIR_FWD);
      en_rev   <= (gap_cnt_n == '0) && (held_dir_n == DIR_REV);
      dir_out  <= (held_dir_n == DIR_REV);
    end
  end
endmodule

// File: rtl/scan_dir_select.sv
module scan_dir_select
  import scan_dir_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic scan_sel,
  input  logic frame_strobe,
  output logic drive_fwd,
  output logic drive_rev,
  output logic scan_dir
);
  scan_dir_e eff_dir;

  sds_strobe_latch u_latch (
    .clk       (clk),
    .rst       (rst),
    .sel_in    (scan_sel),
    .strobe_in (frame_strobe),
    .eff_dir   (eff_dir)
  );

  sds_gap_timer #(
    .DEAD_CYC (DEAD_CYC)
  ) u_gap (
    .clk      (clk),
    .rst      (rst),
    .want_dir (eff_dir),
    .en_fwd   (drive_fwd),
    .en_rev   (drive_rev),
    .dir_out  (scan_dir)
  );
endmodule

// File: rtl/scan_dir_select_chk.sv
module scan_dir_select_chk #(
  parameter int unsigned DEAD_CYC = 125
) (
  input logic clk,
  input logic rst,
  input logic scan_sel,
  input logic frame_strobe,
  input logic drive_fwd,
  input logic drive_rev,
  input logic scan_dir
);
  int unsigned low_run;
  logic        strobe_prev;

  always_ff @(posedge clk) begin
    strobe_prev <= frame_strobe;
    if (rst || drive_fwd || drive_rev) low_run <= 0;
    else if (low_run < DEAD_CYC + 8) low_run <= low_run + 1;
  end

  p_never_both_r1: assert property (@(posedge clk) disable iff (rst)
    !(drive_fwd && drive_rev));

  p_dir_matches_r1: assert property (@(posedge clk) disable iff (rst)
    (drive_rev |-> scan_dir) and (drive_fwd |-> !scan_dir));

  p_sel_forces_rev_r3: assert property (@(posedge clk) disable iff (rst)
    scan_sel |=> (!drive_fwd && scan_dir));

  p_capture_high_r2: assert property (@(posedge clk) disable iff (rst)
    (frame_strobe && !strobe_prev && scan_sel) |=> ##1 scan_dir);

  p_break_first_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(drive_fwd) || $rose(drive_rev)) |-> $past(!drive_fwd && !drive_rev));

  p_gap_long_r6: assert property (@(posedge clk) disable iff (rst)
    ($rose(drive_fwd) || $rose(drive_rev)) |-> (low_run >= DEAD_CYC));
endmodule

bind scan_dir_select scan_dir_select_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .scan_sel     (scan_sel),
  .frame_strobe (frame_strobe),
  .drive_fwd    (drive_fwd),
  .drive_rev    (drive_rev),
  .scan_dir     (scan_dir)
);

// File: tb/scan_dir_select_test.sv
`timescale 1ns/1ps
module scan_dir_select_test;
  localparam int D = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scan_sel = 1'b0;
  logic frame_strobe = 1'b0;
  logic drive_fwd, drive_rev, scan_dir;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  scan_dir_select #(.DEAD_CYC(D)) uut (
    .clk(clk), .rst(rst), .scan_sel(scan_sel), .frame_strobe(frame_strobe),
    .drive_fwd(drive_fwd), .drive_rev(drive_rev), .scan_dir(scan_dir)
  );

  // Behavioural reference: what the ports should show after each edge.
  int m_flag, m_dir, m_left, m_prev_st;
  int e_fwd = 1, e_rev = 0, e_dir = 0;
  always @(posedge clk) begin
    int want;
    if (rst) begin
      m_flag = 0; m_dir = 0; m_left = 0;
    end else begin
      want = (scan_sel || m_flag) ? 1 : 0;
      if (frame_strobe && !m_prev_st) m_flag = scan_sel;
      if (want != m_dir) begin
        m_dir = want; m_left = D;
      end else if (m_left > 0) begin
        m_left = m_left - 1;
      end
    end
    m_prev_st = frame_strobe;
    e_fwd = (m_left == 0 && m_dir == 0) ? 1 : 0;
    e_rev = (m_left == 0 && m_dir == 1) ? 1 : 0;
    e_dir = m_dir;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the reference (R1 steady, R5 during gaps).
  always @(negedge clk) begin
    if (!done) begin
      check((m_left > 0) ? "R5 model fwd" : "R1 model fwd", int'(drive_fwd), e_fwd);
      check((m_left > 0) ? "R5 model rev" : "R1 model rev", int'(drive_rev), e_rev);
      check("R1 model dir", int'(scan_dir), e_dir);
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Counts negedges with both enables low; optionally flips select at count flip_at.
  task automatic gap_len(output int n, input int flip_at, input logic flip_val);
    n = 0;
    while (!(drive_fwd || drive_rev) && n < 10 * D) begin
      n++;
      if (n == flip_at) scan_sel = flip_val;
      @(negedge clk);
    end
  endtask

  task automatic pulse_strobe();
    frame_strobe = 1'b1;
    @(negedge clk);
    frame_strobe = 1'b0;
  endtask

  initial begin
    int n;
    @(negedge clk);
    cycles(3);
    // R7 reset values
    check("R7 fwd in reset", int'(drive_fwd), 1);
    check("R7 rev in reset", int'(drive_rev), 0);
    check("R7 dir in reset", int'(scan_dir), 0);
    rst = 1'b0;
    cycles(5);
    check("R7 no startup gap", int'(drive_fwd), 1);

    // R3 raw select high, R5 gap length
    scan_sel = 1'b1;
    @(negedge clk);
    check("R3 fwd off at once", int'(drive_fwd), 0);
    check("R3 dir reverse at once", int'(scan_dir), 1);
    gap_len(n, 0, 1'b0);
    check("R5 gap length to reverse", n, D);
    check("R1 reverse enable", int'(drive_rev), 1);

    // R3 flag clear: select low returns to forward
    scan_sel = 1'b0;
    @(negedge clk);
    gap_len(n, 0, 1'b0);
    check("R5 gap length to forward", n, D);
    check("R3 follows select with flag clear", int'(drive_fwd), 1);

    // R2/R4 capture reverse, then select low keeps reverse
    scan_sel = 1'b1;
    pulse_strobe();
    cycles(D + 3);
    scan_sel = 1'b0;
    cycles(4 * D);
    check("R4 reverse held by flag", int'(drive_rev), 1);
    check("R2 captured direction", int'(scan_dir), 1);
    pulse_strobe();
    cycles(1);
    check("R4 gap after strobe samples low", int'(drive_rev), 0);
    cycles(D + 2);
    check("R4 forward restored", int'(drive_fwd), 1);

    // R6 change back during a gap reloads the count
    scan_sel = 1'b1;
    @(negedge clk);
    gap_len(n, 3, 1'b0);
    check("R6 reloaded gap length", n, 3 + D);
    check("R6 ends forward", int'(drive_fwd), 1);

    // R2 strobe held high captures nothing further
    frame_strobe = 1'b1;
    cycles(2);
    scan_sel = 1'b1;
    cycles(D + 4);
    check("R2 raw reverse while strobe high", int'(drive_rev), 1);
    scan_sel = 1'b0;
    cycles(D + 4);
    check("R2 level strobe did not capture", int'(drive_fwd), 1);
    frame_strobe = 1'b0;
    cycles(3);

    // R7 reset mid-reverse returns to forward without a gap
    scan_sel = 1'b1;
    pulse_strobe();
    cycles(D + 3);
    scan_sel = 1'b0;
    rst = 1'b1;
    cycles(2);
    rst = 1'b0;
    cycles(3);
    check("R7 reset clears flag", int'(drive_fwd), 1);
    check("R7 reset dir", int'(scan_dir), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule